// File: doc/BRIEF.md
# External Interrupt Input Detector

The block watches a set of active-low external interrupt pins and turns each one into an interrupt request for a priority controller. Each pin first passes through a two-flop synchronizer. A sample strobe then marks machine-cycle boundaries, and the synchronized pin is sampled only on those boundaries. A per-input trigger bit selects how the request is formed. In level mode the request follows the inverted synchronized pin and is never latched. In edge mode a sticky flag is set when one strobe sample is high and the next is low.

The sticky flag is cleared by a hardware acknowledge pulse, which the controller issues when it vectors the interrupt, or by a software clear pulse. If a new falling edge is detected in the same cycle as a clear, the set wins, so no edge is lost. A separate combinational wake-up output is raised when any enabled input has its raw pin low or an edge flag pending. This lets the power controller leave idle or power-down even while the sampling clock is stopped.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset, with all pins held high and every input in level mode, every bit of `req_o` is 0 and `wake_o` is 0.
- R2: In level mode (`edge_mode_i` bit = 0), `req_o` bit becomes 1 two clock edges after its pin is driven low. The delay comes from the two synchronizer flops and does not depend on `sample_en_i`.
- R3: In level mode the request is not latched: `req_o` returns to 0 two clock edges after the pin returns high.
- R4: In edge mode (`edge_mode_i` bit = 1), with `sample_en_i` held at 1, a high-to-low pin transition sets `req_o` at the third clock edge after the pin falls. The third edge is the one whose strobe sample first sees the low value.
- R5: The edge-mode flag is sticky: it stays set after the pin returns high until it is cleared.
- R6: Samples are taken only on clock edges where `sample_en_i` = 1. A low excursion that lies wholly between strobes sets no flag. A pin that fell while the strobe was off sets the flag at the first strobe that sees it low.
- R7: A one-cycle `ack_i` pulse on an input clears its edge-mode flag at that clock edge.
- R8: A one-cycle `sw_clr_i` pulse on an input clears its edge-mode flag at that clock edge.
- R9: When a falling-edge detection and an acknowledge or software clear fall on the same clock edge, the flag ends up set.
- R10: `wake_o` is combinational. It is 1 whenever an input with `enable_i` = 1 has its raw pin low, or has its edge flag set.
- R11: An input with `enable_i` = 0 never raises `wake_o`, whatever its pin or flag state.
- R12: While an input is in level mode its edge flag is held clear. A flag pending when the input switches to level mode is therefore gone when it switches back to edge mode.
- R13: Each input is independent: the pin, acknowledge and clear of one input do not change the request of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sample_en_i | input | 1 | Machine-cycle strobe; samples are taken when 1 |
| pin_i | input | N_IRQ | Raw asynchronous interrupt pins, active low |
| edge_mode_i | input | N_IRQ | Trigger type per input: 0 level, 1 falling edge |
| enable_i | input | N_IRQ | Per-input enable for wake-up |
| ack_i | input | N_IRQ | Hardware acknowledge pulse, clears the edge flag |
| sw_clr_i | input | N_IRQ | Software clear pulse, clears the edge flag |
| req_o | output | N_IRQ | Interrupt request toward the priority controller |
| wake_o | output | 1 | Combinational wake-up request |

## Verification
Assertions check on every cycle that a strobe sample pair of high then low sets the flag, that the flag never rises without such a pair, and that clears without a coincident set drop the flag. They also check that the previous sample holds between strobes, that level mode keeps the flag clear, and that an enabled low pin always drives `wake_o`. The exact latency through the synchronizer, the sticky behaviour across long sequences, and the set-over-clear collision are shown by the bench's scenarios. The same holds for strobe gating, channel independence and the mode-switch flag loss. The bench sweeps all 4-cycle pin patterns in edge mode against a count computed from the pattern.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  typedef enum logic {
    TRIG_LEVEL = 1'b0,
    TRIG_EDGE  = 1'b1
  } trig_e;

  localparam int unsigned SYNC_STAGES_DEF = 2;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  // resets to 1: pins idle high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_channel.sv
module ext_irq_channel
  import ext_irq_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sample_en_i,
  input  logic pin_sync_i,
  input  logic edge_mode_i,
  input  logic ack_i,
  input  logic clr_i,
  output logic req_o,
  output logic flag_o
);
  trig_e mode;
  logic  prev_q;
  logic  flag_q;
  logic  fall_det;

  assign mode     = trig_e'(edge_mode_i);
  assign fall_det = sample_en_i & prev_q & ~pin_sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          prev_q <= 1'b1;
    else if (sample_en_i) prev_q <= pin_sync_i;
  end

  // set has priority over clear so no edge is lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 flag_q <= 1'b0;
    else if (mode == TRIG_LEVEL) flag_q <= 1'b0;
    else if (fall_det)           flag_q <= 1'b1;
    else if (ack_i || clr_i)     flag_q <= 1'b0;
  end

  assign req_o  = (mode == TRIG_EDGE) ? flag_q : ~pin_sync_i;
  assign flag_o = flag_q;

  AST_EDGE_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_mode_i && sample_en_i && prev_q && !pin_sync_i) |=> flag_q); // R4
  AST_NO_SPURIOUS_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_q && !(sample_en_i && prev_q && !pin_sync_i)) |=> !flag_q); // R6
  AST_CLEAR_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ack_i || clr_i) && !(sample_en_i && prev_q && !pin_sync_i)) |=> !flag_q); // R7
  AST_STROBE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |=> $stable(prev_q)); // R6
  AST_LEVEL_NO_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_mode_i |=> !flag_q); // R12
endmodule

// File: rtl/ext_irq_wake.sv
module ext_irq_wake #(
  parameter int unsigned N_IRQ = 2
) (
  input  logic [N_IRQ-1:0] pin_raw_i,
  input  logic [N_IRQ-1:0] enable_i,
  input  logic [N_IRQ-1:0] flag_i,
  output logic             wake_o
);
  // no clock on this path: must work with clocks gated off
  assign wake_o = |(enable_i & (~pin_raw_i | flag_i));
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import ext_irq_pkg::*;
#(
  parameter int unsigned N_IRQ       = 2,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sample_en_i,
  input  logic [N_IRQ-1:0] pin_i,
  input  logic [N_IRQ-1:0] edge_mode_i,
  input  logic [N_IRQ-1:0] enable_i,
  input  logic [N_IRQ-1:0] ack_i,
  input  logic [N_IRQ-1:0] sw_clr_i,
  output logic [N_IRQ-1:0] req_o,
  output logic             wake_o
);
  logic [N_IRQ-1:0] pin_sync;
  logic [N_IRQ-1:0] flag;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_ch
    ext_irq_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_i[g]),
      .q_o   (pin_sync[g])
    );

    ext_irq_channel i_ch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sample_en_i(sample_en_i),
      .pin_sync_i (pin_sync[g]),
      .edge_mode_i(edge_mode_i[g]),
      .ack_i      (ack_i[g]),
      .clr_i      (sw_clr_i[g]),
      .req_o      (req_o[g]),
      .flag_o     (flag[g])
    );
  end

  ext_irq_wake #(.N_IRQ(N_IRQ)) i_wake (
    .pin_raw_i(pin_i),
    .enable_i (enable_i),
    .flag_i   (flag),
    .wake_o   (wake_o)
  );

  always_comb begin
    if (rst_ni) begin
      AST_WAKE_ON_LOW: assert (((enable_i & ~pin_i) == '0) || wake_o); // R10
      AST_WAKE_MASKED: assert ((enable_i != '0) || !wake_o);           // R11
    end
  end
endmodule

// File: tb/test_ext_irq_detect.sv
module test_ext_irq_detect;
  localparam int N = 2;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sample_en = 1'b1;
  logic [N-1:0] pin = '1, edge_mode = '0, enable = '0, ack = '0, clr = '0;
  logic [N-1:0] req;
  logic         wake;
  int           n_chk = 0, n_fail = 0;
  bit           done = 1'b0;

  always #2.5 clk = ~clk;

  ext_irq_detect #(.N_IRQ(N)) i_ext_irq_detect (
    .clk_i(clk), .rst_ni(rst_n), .sample_en_i(sample_en), .pin_i(pin),
    .edge_mode_i(edge_mode), .enable_i(enable), .ack_i(ack), .sw_clr_i(clr),
    .req_o(req), .wake_o(wake)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_all();
    clr = '1; tick(1); clr = '0;
  endtask

  initial begin
    fork
      begin
        tick(1); rst_n = 1'b1; tick(1);
        chk("R1 req after reset", 8'(req), 8'h0);
        chk("R1 wake after reset", 8'(wake), 8'h0);

        // level mode latency and non-latching
        pin[0] = 1'b0; tick(1);
        chk("R2 level not yet", 8'(req[0]), 8'h0);
        tick(1);
        chk("R2 level after two edges", 8'(req[0]), 8'h1);
        chk("R13 other channel quiet", 8'(req[1]), 8'h0);
        pin[0] = 1'b1; tick(2);
        chk("R3 level released", 8'(req[0]), 8'h0);

        // edge mode basic
        edge_mode = '1; tick(3);
        pin[0] = 1'b0; tick(2);
        chk("R4 edge not yet", 8'(req[0]), 8'h0);
        tick(1);
        chk("R4 edge set", 8'(req[0]), 8'h1);
        pin[0] = 1'b1; tick(4);
        chk("R5 sticky", 8'(req[0]), 8'h1);
        chk("R13 ch1 untouched", 8'(req[1]), 8'h0);
        ack[1] = 1'b1; tick(1); ack[1] = 1'b0;
        chk("R13 ack other keeps", 8'(req[0]), 8'h1);
        ack[0] = 1'b1; tick(1); ack[0] = 1'b0;
        chk("R7 ack clears", 8'(req[0]), 8'h0);

        // software clear
        pin[1] = 1'b0; tick(3); pin[1] = 1'b1; tick(3);
        chk("R5 ch1 set", 8'(req), 8'h2);
        clr[1] = 1'b1; tick(1); clr[1] = 1'b0;
        chk("R8 sw clear", 8'(req[1]), 8'h0);

        // collision: set wins
        pin[0] = 1'b0; tick(2); ack[0] = 1'b1; tick(1); ack[0] = 1'b0;
        chk("R9 set beats ack", 8'(req[0]), 8'h1);
        pin[0] = 1'b1; tick(3); clear_all();
        pin[0] = 1'b0; tick(2); clr[0] = 1'b1; tick(1); clr[0] = 1'b0;
        chk("R9 set beats sw clear", 8'(req[0]), 8'h1);
        pin[0] = 1'b1; tick(3); clear_all();

        // strobe gating
        sample_en = 1'b0;
        pin[0] = 1'b0; tick(5); pin[0] = 1'b1; tick(4);
        chk("R6 excursion between strobes", 8'(req[0]), 8'h0);
        pin[0] = 1'b0; tick(4);
        chk("R6 no strobe no set", 8'(req[0]), 8'h0);
        sample_en = 1'b1; tick(1); sample_en = 1'b0;
        chk("R6 first strobe sets", 8'(req[0]), 8'h1);
        pin[0] = 1'b1; sample_en = 1'b1; tick(4); clear_all();

        // wake-up
        enable = 2'b01; pin[0] = 1'b0; #1;
        chk("R10 wake on enabled low pin", 8'(wake), 8'h1);
        enable = 2'b00; #1;
        chk("R11 disabled no wake", 8'(wake), 8'h0);
        tick(3); pin[0] = 1'b1; tick(3);
        chk("R11 flag set but disabled", 8'(wake), 8'h0);
        enable = 2'b01; #1;
        chk("R10 wake on pending flag", 8'(wake), 8'h1);
        enable = 2'b10; #1;
        chk("R11 other enable no wake", 8'(wake), 8'h0);
        enable = '0;

        // mode switch drops flag
        edge_mode[0] = 1'b0; tick(1);
        chk("R12 level shows pin", 8'(req[0]), 8'h0);
        edge_mode[0] = 1'b1; #1;
        chk("R12 flag lost", 8'(req[0]), 8'h0);
        tick(2);

        // sweep all 4-cycle patterns in edge mode on ch0
        for (int p = 0; p < 16; p++) begin
          automatic logic prev = 1'b1;
          automatic logic exp = 1'b0;
          for (int b = 0; b < 4; b++) begin
            if (prev && !p[b]) exp = 1'b1;
            prev = p[b];
            pin[0] = p[b]; tick(1);
          end
          pin[0] = 1'b1; tick(4);
          chk($sformatf("R4 sweep pattern %0d", p), 8'(req[0]), 8'(exp));
          clear_all();
          chk("R8 sweep cleared", 8'(req[0]), 8'h0);
        end
      end
      begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
      end
    join_any
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule